// File: doc/BRIEF.md
# Debug Trace Capture Array

This block records a wide debug bus into a small circular store so that recent activity can be inspected after the fact. While it runs, the block writes one 128-bit row on every clock. A 2-bit select in a configuration register chooses which of four incoming buses is recorded. The rows are written at a write pointer that wraps around the store. Software drives the block through a plain register port. Writing the control register starts, stops or resets capture. Once capture has stopped, the recorded rows are fetched as two 64-bit halves through a high data register and a low data register.

Readout is sequential and changes state. When capture stops, the read pointer is placed on the oldest recorded row. Every read of either data register then moves the pointer one row forward, wrapping at the end of the store. A full lap of reads brings the pointer back to where it began. The usual sequence is as follows. Read the low halves of the wanted rows. Issue dummy low reads until the pointer has wrapped back to the first row. Then read the high halves in the same order. While capture is active, the low register shows only a running flag, and data reads leave the pointer where it is.

Top module: `dbg_trace_capture`

## Requirements
- R1: While running, the block stores the selected bus into the row at the write pointer on every clock edge that carries no stop or reset command. The write pointer wraps after 16 rows, and a wrapped flag is set when row 15 is written.
- R2: A write to the control register (select 0) decodes its bits with bit 0 as the most significant bit of the 64-bit word. Bit 0 (value bit 63) starts capture, bit 1 (value bit 62) stops it and bit 2 (value bit 61) resets it. When several of these bits are set, reset wins over stop, and stop wins over start.
- R3: A stop while running places the read pointer on the oldest row. This is the write pointer if the store has wrapped, otherwise row 0. Successive reads then return rows from oldest to newest.
- R4: While running, the low data register (select 3) reads as value 1: the running flag in value bit 0, with all other bits zero. When stopped, it returns the full low half of the row at the read pointer.
- R5: A read of either data register made while running does not move the read pointer.
- R6: When stopped, each read of the high or low data register advances the read pointer by one, modulo 16. Sixteen reads return the pointer to its starting row.
- R7: The high data register (select 2) returns bits 127:64 of the row at the read pointer. The low register returns bits 63:0.
- R8: The configuration register (select 1) holds the bus select in bits 14 to 15 (value bits 49:48, bit 14 being the more significant). The field reads back with all other bits zero, and it chooses which of the four input buses is recorded from the next capture on.
- R9: A reset command clears the running state, both pointers and the wrapped flag. It leaves the stored rows and the bus select unchanged.
- R10: Read data is combinational from the current state. The control register reads as zero, and register reads cause no change other than the data-register pointer advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trc_in0 | input | 128 | Trace bus for select value 0 |
| trc_in1 | input | 128 | Trace bus for select value 1 |
| trc_in2 | input | 128 | Trace bus for select value 2 |
| trc_in3 | input | 128 | Trace bus for select value 3 |
| reg_sel | input | 2 | Register select: 0 control, 1 configuration, 2 high data, 3 low data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |

## Verification
A wrong read pointer appears at once as wrong data on the next data-register read. A missed advance repeats a row, and a wrong reload on stop starts the readout at a row other than the oldest. Both show up in the first read after the fault. A wrong write pointer or wrapped flag stays hidden until capture stops, and then appears as rows out of time order. The bench catches this by checking that the cycle stamp rises by one per row. A running state that lingers or clears early appears in the next low-register read as the running flag where data was expected, or the other way round.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int REG_W   = 64;
  localparam int NUM_BUS = 4;
  localparam int BSEL_W  = $clog2(NUM_BUS);

  // Bit numbering counts from the most significant bit (bit 0 = value bit 63)
  localparam int CMD_START_BIT = REG_W - 1 - 0;
  localparam int CMD_STOP_BIT  = REG_W - 1 - 1;
  localparam int CMD_RESET_BIT = REG_W - 1 - 2;
  localparam int BSEL_MSB      = REG_W - 1 - 14;
  localparam int BSEL_LSB      = REG_W - 1 - 15;
  localparam int RUN_FLAG_BIT  = 0;

  typedef enum logic [1:0] {
    RS_CTRL = 2'd0,
    RS_CFG  = 2'd1,
    RS_HI   = 2'd2,
    RS_LO   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dtc_mem.sv
module dtc_mem #(
  parameter int ROW_W = 128,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [ROW_W-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [ROW_W-1:0] rdata
);
  logic [ROW_W-1:0] rows_q [DEPTH];

  // Storage carries no reset; contents survive the reset command
  always_ff @(posedge clk) begin
    if (we) begin
      rows_q[waddr] <= wdata;
    end
  end

  assign rdata = rows_q[raddr];
endmodule

// File: rtl/dtc_seq.sv
module dtc_seq #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_reset,
  input  logic             data_rd,
  output logic             running,
  output logic             cap_en,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic             run_q, run_d;
  logic             wrap_q, wrap_d;
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic             upd_en;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  always_comb begin
    run_d  = run_q;
    wrap_d = wrap_q;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cap_en = 1'b0;
    if (cmd_reset) begin
      run_d  = 1'b0;
      wrap_d = 1'b0;
      wptr_d = '0;
      rptr_d = '0;
    end else if (cmd_stop) begin
      if (run_q) begin
        run_d  = 1'b0;
        rptr_d = wrap_q ? wptr_q : '0;
      end
    end else begin
      if (cmd_start) begin
        run_d = 1'b1;
      end
      if (run_q) begin
        cap_en = 1'b1;
        wptr_d = step(wptr_q);
        if (wptr_q == LAST) begin
          wrap_d = 1'b1;
        end
      end else if (data_rd) begin
        rptr_d = step(rptr_q);
      end
    end
  end

  assign upd_en = cmd_reset | cmd_stop | cmd_start | run_q | data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wrap_q <= 1'b0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (upd_en) begin
      run_q  <= run_d;
      wrap_q <= wrap_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  assign running = run_q;
  assign wptr    = wptr_q;
  assign rptr    = rptr_q;

  assert_wptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !cmd_stop && !cmd_reset) |=>
      (wptr_q == (($past(wptr_q) == LAST) ? '0 : PTR_W'($past(wptr_q) + 1'b1))));

  assert_stop_oldest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cmd_stop && !cmd_reset) |=>
      (!run_q && rptr_q == ($past(wrap_q) ? $past(wptr_q) : '0)));

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && data_rd && !cmd_stop && !cmd_reset) |=> $stable(rptr_q));

  assert_rd_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && data_rd && !cmd_reset && !cmd_start) |=>
      (rptr_q == (($past(rptr_q) == LAST) ? '0 : PTR_W'($past(rptr_q) + 1'b1))));

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!run_q && !wrap_q && wptr_q == '0 && rptr_q == '0));
endmodule

// File: rtl/dbg_trace_capture.sv
module dbg_trace_capture #(
  parameter int DEPTH = 16,
  localparam int REG_W = dtc_pkg::REG_W,
  localparam int ROW_W = 2 * REG_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int BSEL_W = dtc_pkg::BSEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] trc_in0,
  input  logic [ROW_W-1:0] trc_in1,
  input  logic [ROW_W-1:0] trc_in2,
  input  logic [ROW_W-1:0] trc_in3,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  import dtc_pkg::*;

  logic             rst_meta_q, rst_sync_q;
  logic [ROW_W-1:0] bus_arr [NUM_BUS];
  logic [BSEL_W-1:0] bsel_q;
  logic             cfg_wr_en;
  logic             ctrl_wr, cmd_start, cmd_stop, cmd_reset, data_rd;
  logic             running, cap_en;
  logic [PTR_W-1:0] wptr, rptr;
  logic [ROW_W-1:0] rd_row;
  reg_sel_e         sel;
  logic             unused_wbits;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign bus_arr[0] = trc_in0;
  assign bus_arr[1] = trc_in1;
  assign bus_arr[2] = trc_in2;
  assign bus_arr[3] = trc_in3;

  assign sel       = reg_sel_e'(reg_sel);
  assign ctrl_wr   = reg_wr && (sel == RS_CTRL);
  assign cmd_start = ctrl_wr && reg_wdata[CMD_START_BIT];
  assign cmd_stop  = ctrl_wr && reg_wdata[CMD_STOP_BIT];
  assign cmd_reset = ctrl_wr && reg_wdata[CMD_RESET_BIT];
  assign data_rd   = reg_rd && ((sel == RS_HI) || (sel == RS_LO));
  assign cfg_wr_en = reg_wr && (sel == RS_CFG);

  assign unused_wbits = ^{reg_wdata[CMD_RESET_BIT-1:BSEL_MSB+1],
                          reg_wdata[BSEL_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      bsel_q <= '0;
    end else if (cfg_wr_en) begin
      bsel_q <= reg_wdata[BSEL_MSB:BSEL_LSB];
    end
  end

  dtc_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_reset (cmd_reset),
    .data_rd   (data_rd),
    .running   (running),
    .cap_en    (cap_en),
    .wptr      (wptr),
    .rptr      (rptr)
  );

  dtc_mem #(.ROW_W(ROW_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (cap_en),
    .waddr (wptr),
    .wdata (bus_arr[bsel_q]),
    .raddr (rptr),
    .rdata (rd_row)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RS_CFG:  reg_rdata[BSEL_MSB:BSEL_LSB] = bsel_q;
      RS_HI:   reg_rdata = rd_row[ROW_W-1:REG_W];
      RS_LO:   reg_rdata = running ? (REG_W'(1) << RUN_FLAG_BIT) : rd_row[REG_W-1:0];
      default: reg_rdata = '0;
    endcase
  end

  assert_lo_flag_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (running && sel == RS_LO) |-> (reg_rdata == (REG_W'(1) << RUN_FLAG_BIT)));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !cfg_wr_en |=> $stable(bsel_q));
endmodule

// File: tb/dbg_trace_capture_tb.sv
`timescale 1ns/1ps
module dbg_trace_capture_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] trc [4];
  logic [1:0]   reg_sel;
  logic         reg_wr, reg_rd;
  logic [63:0]  reg_wdata;
  logic [63:0]  reg_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] cyc = 0;

  // Reference state, built from the requirements
  logic [127:0] m_mem [16];
  logic         m_run, m_wrap;
  logic [3:0]   m_wptr, m_rptr;
  logic [1:0]   m_bsel;

  always #5 clk = ~clk;

  dbg_trace_capture u_dut (
    .clk (clk), .rst_n (rst_n),
    .trc_in0 (trc[0]), .trc_in1 (trc[1]), .trc_in2 (trc[2]), .trc_in3 (trc[3]),
    .reg_sel (reg_sel), .reg_wr (reg_wr), .reg_rd (reg_rd),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
  );

  // Bus stimulus: tag byte, fixed filler, cycle stamp, inverted stamp, scaled stamp
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int k = 0; k < 4; k++)
      trc[k] <= {8'(k), 24'h5A5A5A, cyc, ~cyc, cyc * 32'd3};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_wrap <= 0; m_wptr <= 0; m_rptr <= 0; m_bsel <= 0;
    end else begin
      if (reg_wr && reg_sel == 2'd1) m_bsel <= reg_wdata[49:48];
      if (reg_wr && reg_sel == 2'd0 && reg_wdata[61]) begin
        m_run <= 0; m_wrap <= 0; m_wptr <= 0; m_rptr <= 0;
      end else if (reg_wr && reg_sel == 2'd0 && reg_wdata[62]) begin
        if (m_run) begin
          m_run <= 0;
          m_rptr <= m_wrap ? m_wptr : 4'd0;
        end
      end else begin
        if (reg_wr && reg_sel == 2'd0 && reg_wdata[63]) m_run <= 1;
        if (m_run) begin
          m_mem[m_wptr] <= trc[m_bsel];
          m_wptr <= m_wptr + 1;
          if (m_wptr == 4'd15) m_wrap <= 1;
        end else if (reg_rd && reg_sel[1]) begin
          m_rptr <= m_rptr + 1;
        end
      end
    end
  end

  function automatic logic [63:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0: return 64'd0;
      2'd1: return {14'd0, m_bsel, 48'd0};
      2'd2: return m_mem[m_rptr][127:64];
      default: return m_run ? 64'd1 : m_mem[m_rptr][63:0];
    endcase
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1; reg_rd = 0;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, input bit chk, input string req, output logic [63:0] val);
    @(negedge clk);
    reg_sel = s; reg_rd = 1; reg_wr = 0;
    #2 val = reg_rdata;
    if (chk) check(reg_rdata, exp_rd(s), req);
    @(posedge clk); #1 reg_rd = 0;
  endtask

  localparam logic [63:0] START = 64'h8000_0000_0000_0000;
  localparam logic [63:0] STOP  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] RESET = 64'h2000_0000_0000_0000;

  task automatic t_reset_state;
    logic [63:0] v;
    rd(2'd1, 1, "R8 cfg after reset", v);
    check(v, 64'd0, "R8 cfg zero after reset");
    rd(2'd0, 1, "R10 ctrl reads zero", v);
    check(v, 64'd0, "R10 ctrl zero");
  endtask

  task automatic t_short;
    logic [63:0] v, first;
    wr(2'd0, START);
    rd(2'd3, 1, "R4 lo while running", v);
    check(v, 64'd1, "R4 running flag");
    repeat (4) @(posedge clk);
    wr(2'd0, STOP);
    for (int i = 0; i < 5; i++) begin
      rd(2'd3, 1, "R7 lo half short", v);
      if (i == 0) first = v;
    end
    for (int i = 0; i < 11; i++) rd(2'd3, 0, "", v);
    for (int i = 0; i < 5; i++) rd(2'd2, 1, "R7 hi half short", v);
    for (int i = 0; i < 11; i++) rd(2'd2, 0, "", v);
    rd(2'd3, 1, "R6 pointer lap", v);
    check(v, first, "R6 sixteen reads return to start");
    check(v, m_mem[0][63:0], "R3 unwrapped readout starts at row 0");
  endtask

  task automatic t_mux;
    logic [63:0] v;
    wr(2'd1, 64'h0002_0000_0000_0000 | 64'hFFFC_FFFF_FFFF_FFFF & 64'h0);
    rd(2'd1, 1, "R8 cfg readback", v);
    check(v, 64'h0002_0000_0000_0000, "R8 select field value bits 49:48");
  endtask

  task automatic t_wrap;
    logic [63:0] v, prev;
    wr(2'd0, START);
    repeat (40) @(posedge clk);
    wr(2'd0, STOP);
    for (int i = 0; i < 16; i++) begin
      rd(2'd2, 1, "R3 hi after wrap", v);
      check({56'd0, v[63:56]}, 64'd2, "R8 captured bus tag");
      if (i > 0) check({32'd0, v[31:0]}, {32'd0, prev[31:0] + 32'd1}, "R3 oldest to newest");
      prev = v;
    end
    for (int i = 0; i < 16; i++) rd(2'd3, 1, "R1 lo after wrap", v);
  endtask

  task automatic t_run_read;
    logic [63:0] v;
    for (int i = 0; i < 3; i++) rd(2'd3, 1, "R6 stopped advance", v);
    wr(2'd0, START);
    for (int i = 0; i < 4; i++) rd(2'd2, 1, "R5 hi read while running", v);
    rd(2'd3, 1, "R5 lo read while running", v);
    check(v, 64'd1, "R4 flag only while running");
    wr(2'd0, STOP);
    rd(2'd3, 1, "R3 oldest after restart", v);
  endtask

  task automatic t_priority;
    logic [63:0] v;
    wr(2'd0, START);
    repeat (3) @(posedge clk);
    wr(2'd0, START | STOP);
    rd(2'd3, 1, "R2 stop beats start", v);
    check({63'd0, v == 64'd1}, 64'd0, "R2 not running after start+stop");
    wr(2'd0, START | STOP | RESET);
    rd(2'd3, 1, "R2 reset beats start", v);
    check(v, m_mem[0][63:0], "R9 reset keeps rows, pointer at 0");
  endtask

  task automatic t_reset_cmd;
    logic [63:0] v;
    wr(2'd0, START);
    repeat (20) @(posedge clk);
    wr(2'd0, RESET);
    rd(2'd1, 1, "R9 select kept over reset", v);
    check(v, 64'h0002_0000_0000_0000, "R9 select kept");
    wr(2'd1, 64'h0003_0000_0000_0000);
    wr(2'd0, START);
    repeat (3) @(posedge clk);
    wr(2'd0, STOP);
    rd(2'd2, 1, "R9 wrap cleared, oldest is row 0", v);
    check({56'd0, v[63:56]}, 64'd3, "R8 new select recorded");
    for (int i = 0; i < 3; i++) rd(2'd3, 1, "R9 rows after reset", v);
    rd(2'd0, 1, "R10 ctrl still zero", v);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    for (int k = 0; k < 4; k++) trc[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    t_reset_state;
    t_short;
    t_mux;
    t_wrap;
    t_run_read;
    t_priority;
    t_reset_cmd;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule